// File: doc/BRIEF.md
# Burst-Only Request Control for a 32-Channel DMA

This block holds one mode bit per DMA channel. The bit selects which kinds of peripheral request the channel accepts. A channel whose bit is clear accepts both single and burst requests. A channel whose bit is set is in burst-only mode: its single request line is masked before the arbiter sees it, and its burst line still passes through. Software changes the bits through two write-one ports, one that sets bits and one that clears them. The current bits are always visible on a read-data output.

The block also watches the transfer engine. Each time the engine reports a finished transfer, it gives the channel index, the number of items still left and the arbitration size, coded as a base-2 logarithm. If fewer items are left than one arbitration unit, the block drops that channel's burst-only bit. This covers two cases: nothing is left at all, or only a short tail remains. Any leftover items can then move by single requests. Burst-only operation returns only when software sets the bit again.

Each channel is a two-state machine with states `CH_ANY` (single and burst accepted) and `CH_BURST` (burst only). The machine has these transitions:
- SW_SET takes `CH_ANY` to `CH_BURST`.
- SW_CLR takes `CH_BURST` to `CH_ANY`.
- AUTO_CLR takes `CH_BURST` to `CH_ANY` after a short-tail or final transfer.
- HOLD keeps the current state.

Top module: `burst_req_ctl`

## Requirements
- R1: After reset every mode bit is 0, so `mode_rdata` reads 0.
- R2: While channel n's bit is 0, `req_single_out[n]` equals `req_single_in[n]`. While the bit is 1, `req_single_out[n]` is 0.
- R3: `req_burst_out` always equals `req_burst_in`, whatever the mode bits are.
- R4: A cycle with `sw_set_stb` high sets the bit of every channel whose `sw_set_mask` bit is 1. The new value shows on `mode_rdata` from the next cycle on.
- R5: A cycle with `sw_clr_stb` high clears the bit of every channel whose `sw_clr_mask` bit is 1, from the next cycle on.
- R6: A mask bit of 0 in either write leaves that channel's bit unchanged, and so does a mask with its strobe low.
- R7: On a `xfer_done` pulse with `xfer_left` equal to 0, the bit of channel `xfer_chan` is cleared in the next cycle.
- R8: On a `xfer_done` pulse, the bit of channel `xfer_chan` is also cleared when `xfer_left` is below 2^`xfer_arb_log2`, and is kept when `xfer_left` is at or above that value. A log2 code above 10 counts as 10, which is 1024 items.
- R9: An automatic clear changes only channel `xfer_chan`. No channel changes without a `xfer_done` pulse.
- R10: If a software set and an automatic clear hit the same channel in the same cycle, the set wins. If a set and a clear are written for the same channel in the same cycle, the bit ends at 0.
- R11: A bit that has been cleared stays 0 through later transfers until software sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_set_stb | input | 1 | Set-register write strobe |
| sw_set_mask | input | NUM_CH | Channels to put in burst-only mode |
| sw_clr_stb | input | 1 | Clear-register write strobe |
| sw_clr_mask | input | NUM_CH | Channels to return to single-and-burst mode |
| mode_rdata | output | NUM_CH | Current mode bits (1 = burst only) |
| req_single_in | input | NUM_CH | Raw single requests from peripherals |
| req_burst_in | input | NUM_CH | Raw burst requests from peripherals |
| req_single_out | output | NUM_CH | Gated single requests to the arbiter |
| req_burst_out | output | NUM_CH | Burst requests to the arbiter |
| xfer_done | input | 1 | One-cycle pulse when a transfer finishes |
| xfer_chan | input | CH_W | Channel index of the finished transfer |
| xfer_left | input | CNT_W | Items still left after that transfer |
| xfer_arb_log2 | input | ARB_W | Arbitration size as a log2 code |

## Verification
Two of the block's functions can land in the same cycle: a software set or clear write, and an engine-driven automatic clear aimed at the same channel. The bench provokes this collision in two ways. First, directed cycles raise the set strobe, or both strobes, in the same cycle as a short-tail `xfer_done` for a channel that is already in burst-only mode. Second, a long random phase produces many chance overlaps. A behavioural model applies the priority rules on every clock, so the outcome of each collision is compared with the bit that the requirements predict.

// File: rtl/burst_ctl_pkg.sv
package burst_ctl_pkg;
    typedef enum logic {
        CH_ANY   = 1'b0,
        CH_BURST = 1'b1
    } ch_mode_e;
endpackage

// File: rtl/burst_autoclr_eval.sv
module burst_autoclr_eval #(
    parameter int NUM_CH       = 32,
    parameter int CH_W         = 5,
    parameter int CNT_W        = 16,
    parameter int ARB_W        = 4,
    parameter int MAX_ARB_LOG2 = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic [CNT_W-1:0]  left_i,
    input  logic [ARB_W-1:0]  arb_log2_i,
    output logic [NUM_CH-1:0] hit_o
);
    localparam int SZ_W = (CNT_W > MAX_ARB_LOG2) ? CNT_W + 1 : MAX_ARB_LOG2 + 2;

    logic [ARB_W-1:0] eff_log2;
    logic [SZ_W-1:0]  arb_items;
    logic [SZ_W-1:0]  left_ext;
    logic             short_tail;

    always_comb begin
        eff_log2   = (arb_log2_i > ARB_W'(MAX_ARB_LOG2)) ? ARB_W'(MAX_ARB_LOG2) : arb_log2_i;
        arb_items  = SZ_W'(1) << eff_log2;
        left_ext   = {{(SZ_W-CNT_W){1'b0}}, left_i};
        short_tail = left_ext < arb_items;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_hit
        assign hit_o[g] = done_i && short_tail && (chan_i == CH_W'(g));
    end

    // R9: an automatic clear names at most one channel, and only on a done pulse
    a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_o));
    a_r9_needs_done: assert property (@(posedge clk) disable iff (!rst_n) !done_i |-> (hit_o == '0));
endmodule

// File: rtl/burst_chan_fsm.sv
module burst_chan_fsm
    import burst_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic auto_i,
    output logic burst_only_o
);
    ch_mode_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_ANY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_ANY:   if (set_i && !clr_i)              state_d = CH_BURST; // SW_SET
            CH_BURST: if (clr_i || (auto_i && !set_i))  state_d = CH_ANY;   // SW_CLR / AUTO_CLR
        endcase
    end

    always_comb begin
        burst_only_o = (state_q == CH_BURST);
    end

    a_r4_set_takes:   assert property (@(posedge clk) disable iff (!rst_n) (set_i && !clr_i) |=> burst_only_o);
    a_r5_clr_takes:   assert property (@(posedge clk) disable iff (!rst_n) clr_i |=> !burst_only_o);
    a_r7_auto_clears: assert property (@(posedge clk) disable iff (!rst_n) (auto_i && !set_i) |=> !burst_only_o);
    a_r11_no_return:  assert property (@(posedge clk) disable iff (!rst_n) (!set_i && !burst_only_o) |=> !burst_only_o);
endmodule

// File: rtl/burst_req_gate.sv
module burst_req_gate #(
    parameter int NUM_CH = 32
) (
    input  logic [NUM_CH-1:0] mode_i,
    input  logic [NUM_CH-1:0] single_i,
    input  logic [NUM_CH-1:0] burst_i,
    output logic [NUM_CH-1:0] single_o,
    output logic [NUM_CH-1:0] burst_o
);
    for (genvar g = 0; g < NUM_CH; g++) begin : g_gate
        assign single_o[g] = single_i[g] & ~mode_i[g];
        assign burst_o[g]  = burst_i[g];
    end
endmodule

// File: rtl/burst_req_ctl.sv
module burst_req_ctl #(
    parameter int  NUM_CH       = 32,
    parameter int  CNT_W        = 16,
    parameter int  ARB_W        = 4,
    parameter int  MAX_ARB_LOG2 = 10,
    localparam int CH_W         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_set_stb,
    input  logic [NUM_CH-1:0] sw_set_mask,
    input  logic              sw_clr_stb,
    input  logic [NUM_CH-1:0] sw_clr_mask,
    output logic [NUM_CH-1:0] mode_rdata,
    input  logic [NUM_CH-1:0] req_single_in,
    input  logic [NUM_CH-1:0] req_burst_in,
    output logic [NUM_CH-1:0] req_single_out,
    output logic [NUM_CH-1:0] req_burst_out,
    input  logic              xfer_done,
    input  logic [CH_W-1:0]   xfer_chan,
    input  logic [CNT_W-1:0]  xfer_left,
    input  logic [ARB_W-1:0]  xfer_arb_log2
);
    logic [NUM_CH-1:0] auto_hit;
    logic [NUM_CH-1:0] mode_bits;

    burst_autoclr_eval #(
        .NUM_CH(NUM_CH), .CH_W(CH_W), .CNT_W(CNT_W),
        .ARB_W(ARB_W), .MAX_ARB_LOG2(MAX_ARB_LOG2)
    ) u_eval (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_i     (xfer_done),
        .chan_i     (xfer_chan),
        .left_i     (xfer_left),
        .arb_log2_i (xfer_arb_log2),
        .hit_o      (auto_hit)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        burst_chan_fsm u_fsm (
            .clk          (clk),
            .rst_n        (rst_n),
            .set_i        (sw_set_stb && sw_set_mask[g]),
            .clr_i        (sw_clr_stb && sw_clr_mask[g]),
            .auto_i       (auto_hit[g]),
            .burst_only_o (mode_bits[g])
        );

        // R2: a burst-only channel never shows a single request to the arbiter
        a_r2_single_masked: assert property (@(posedge clk) disable iff (!rst_n)
            mode_rdata[g] |-> !req_single_out[g]);
        // R6: with no write and no done pulse, a bit does not move
        a_r6_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
            (!sw_set_stb && !sw_clr_stb && !xfer_done) |=> $stable(mode_rdata[g]));
    end

    burst_req_gate #(.NUM_CH(NUM_CH)) u_gate (
        .mode_i   (mode_bits),
        .single_i (req_single_in),
        .burst_i  (req_burst_in),
        .single_o (req_single_out),
        .burst_o  (req_burst_out)
    );

    assign mode_rdata = mode_bits;
endmodule

// File: tb/burst_req_ctl_bench.sv
module burst_req_ctl_bench;
    localparam int N = 32;
    localparam int WATCHDOG = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        set_stb = 1'b0, clr_stb = 1'b0;
    logic [N-1:0] set_mask = '0, clr_mask = '0;
    logic [N-1:0] mode_rd, s_in = '0, b_in = '0, s_out, b_out;
    logic        done = 1'b0;
    logic [4:0]  chan = '0;
    logic [15:0] left = '0;
    logic [3:0]  arb = '0;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    logic [N-1:0] model = '0;

    always #10 clk = ~clk;

    burst_req_ctl u_burst_req_ctl (
        .clk(clk), .rst_n(rst_n),
        .sw_set_stb(set_stb), .sw_set_mask(set_mask),
        .sw_clr_stb(clr_stb), .sw_clr_mask(clr_mask),
        .mode_rdata(mode_rd),
        .req_single_in(s_in), .req_burst_in(b_in),
        .req_single_out(s_out), .req_burst_out(b_out),
        .xfer_done(done), .xfer_chan(chan), .xfer_left(left), .xfer_arb_log2(arb)
    );

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        check(tag, mode_rd, model);
        check("R2 gated single", s_out, s_in & ~model);
        check("R3 burst pass", b_out, b_in);
    endtask

    // one clock: predict from the requirements, clock, compare, drop strobes
    task automatic step(input string tag);
        logic [N-1:0] nxt;
        int lim;
        lim = (arb > 10) ? 1024 : (1 << arb);
        nxt = model;
        for (int n = 0; n < N; n++) begin
            if (clr_stb && clr_mask[n])                      nxt[n] = 1'b0;
            else if (set_stb && set_mask[n])                 nxt[n] = 1'b1;
            else if (done && (int'(chan) == n) && (int'(left) < lim)) nxt[n] = 1'b0;
        end
        @(posedge clk);
        model = nxt;
        @(negedge clk);
        #1;
        compare_all(tag);
        set_stb = 1'b0; clr_stb = 1'b0; done = 1'b0;
        set_mask = '0;  clr_mask = '0;
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R1..: actual=hung expected=finished");
        finish_up();
    end

    initial begin
        s_in = '1; b_in = 32'hA5A5_0F0F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        compare_all("R1 reset state");

        // R4 set, with pattern on single lines for R2
        set_stb = 1'b1; set_mask = 32'h0000_00F0; step("R4 set bits 4..7");
        set_stb = 1'b1; set_mask = 32'h8000_0001; step("R4 set bits 0,31");
        s_in = 32'h5555_AAAA; b_in = 32'hFFFF_0000; step("R2 R3 pattern hold");

        // R6 zero masks and mask without strobe
        set_stb = 1'b1; set_mask = '0; step("R6 set zero mask");
        clr_stb = 1'b1; clr_mask = '0; step("R6 clr zero mask");
        set_mask = 32'h0F00_0000; step("R6 mask without strobe");

        // R5 clear
        clr_stb = 1'b1; clr_mask = 32'h0000_0030; step("R5 clear bits 4,5");

        // R7 final transfer, multiple of arb size
        set_stb = 1'b1; set_mask = 32'h0000_0020; step("R4 set ch5");
        done = 1'b1; chan = 5; left = 0; arb = 2; step("R7 final clear ch5");

        // R8 short tail and full burst left
        set_stb = 1'b1; set_mask = 32'h0000_0300; step("R4 set ch8,9");
        done = 1'b1; chan = 8; left = 4; arb = 2; step("R8 keep when left==arb");
        done = 1'b1; chan = 8; left = 3; arb = 2; step("R8 clear when left<arb");
        done = 1'b1; chan = 9; left = 1000; arb = 15; step("R8 clamp 1024 clears");
        set_stb = 1'b1; set_mask = 32'h0000_0200; step("R4 reset ch9");
        done = 1'b1; chan = 9; left = 1024; arb = 12; step("R8 clamp keeps 1024");

        // R9 only the named channel changes
        set_stb = 1'b1; set_mask = 32'h0000_7000; step("R4 set ch12..14");
        done = 1'b1; chan = 13; left = 0; arb = 0; step("R9 only ch13 clears");

        // R10 collisions
        done = 1'b1; chan = 12; left = 1; arb = 3;
        set_stb = 1'b1; set_mask = 32'h0000_1000; step("R10 set beats auto");
        done = 1'b1; chan = 12; left = 1; arb = 3;
        set_stb = 1'b1; set_mask = 32'h0000_1000;
        clr_stb = 1'b1; clr_mask = 32'h0000_1000; step("R10 set+clr ends 0");
        set_stb = 1'b1; set_mask = 32'h0001_0000;
        clr_stb = 1'b1; clr_mask = 32'h0001_0000; step("R10 set+clr on idle ch");

        // R11 stays clear after auto-clear
        for (int k = 0; k < 4; k++) begin
            done = 1'b1; chan = 13; left = 16'(500 + k); arb = 1;
            step("R11 stays clear");
        end

        // random phase, compared on every clock
        for (int k = 0; k < 600; k++) begin
            s_in = $urandom; b_in = $urandom;
            set_stb = ($urandom_range(0, 2) == 0); set_mask = $urandom & $urandom;
            clr_stb = ($urandom_range(0, 3) == 0); clr_mask = $urandom & $urandom & $urandom;
            done = ($urandom_range(0, 1) == 0);
            chan = 5'($urandom); left = 16'($urandom_range(0, 1100)); arb = 4'($urandom);
            step("R10 random mix");
        end
        finish_up();
    end
endmodule